// File: doc/BRIEF.md
# Polynomial Coefficient Adapter with Momentum

This block runs the background loop that tunes the three odd-order coefficients of a digital inverse polynomial used to linearise an amplifier. Each accepted sample brings a signed error estimate, a signed first-stage code and a one-bit two-level dither. For every order m in {1, 3, 5}, the block forms a correlation product: the error, times the code raised to the power m-1, times the dither sign. It sums each product over a fixed window of accepted samples.

When a window closes, each coefficient moves by a step-scaled copy of its window sum plus a momentum share of its previous move. The accumulate-and-update loop acts as a discrete-time integrator, so each coefficient settles where its correlation has zero mean. The same dither bit feeds all three loops. The coefficients are held on output ports for the correction datapath. A one-cycle strobe flags each change.

Coefficients are signed fixed point with 20 fractional bits at the default width of 24, so the value 0.25 is 262144. The step factor is MU_MULT / 2^MU_SHIFT. The momentum factor is MOM_MULT / 2^MOM_SHIFT. The defaults approximate a step of 1e-4 divided by a 1000-sample window, and a momentum constant of 0.85.

Top module: `coef_adapter`

## Requirements
- R1: During and after reset, coefA1 equals A1_INIT (default 262144, i.e. 0.25), coefA3 and coefA5 equal A3_INIT and A5_INIT (default 0), and coefUpdate is low. The stored previous update of every order is zero after reset, so a first window whose error samples are all zero leaves every coefficient unchanged.
- R2: For an accepted sample with error e, code c and dither bit s, the product added for orders 1, 3 and 5 is sgn·e, sgn·e·c² and sgn·e·c⁴. Here sgn = +1 when ditherBit is 1 and -1 when it is 0. e and c are read as two's-complement numbers.
- R3: A window holds exactly WIN_LEN samples. Each sample is counted only in a cycle with sampleValid high. Cycles with sampleValid low change neither the sums nor the window count.
- R4: At each window close, each order computes delta = floor(S·MU_MULT / 2^MU_SHIFT) + floor(P·MOM_MULT / 2^MOM_SHIFT). S is that order's window sum and P is its stored previous update. Both shifts are arithmetic, so they round toward minus infinity.
- R5: The stored previous update of an order becomes the delta that was applied, after clamping. It is kept across windows, so with all-zero error the coefficients keep moving by a decaying momentum share.
- R6: Coefficients take their new values at the clock edge that follows the edge accepting a window's final sample. coefUpdate is high for exactly the one cycle that starts at that edge.
- R7: Between updates, coefA1, coefA3 and coefA5 hold their values.
- R8: A sample accepted in the cycle right after a window closes, including while the update is being written, counts as the first sample of the next window.
- R9: delta is clamped to the signed COEF_W-bit range. Coefficient + delta is clamped to the same range rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Marks a sample to accept this cycle |
| errIn | input | ERR_W | Signed error estimate |
| codeIn | input | CODE_W | Signed first-stage code |
| ditherBit | input | 1 | Dither: 1 means +1, 0 means -1 |
| coefA1 | output | COEF_W | First-order coefficient, signed fixed point |
| coefA3 | output | COEF_W | Third-order coefficient |
| coefA5 | output | COEF_W | Fifth-order coefficient |
| coefUpdate | output | 1 | One-cycle pulse when new coefficients appear |

## Verification
Sample accumulation and the coefficient write can fall in the same cycle. A window can close while valid samples keep arriving, so the update of the finished window is being written while the next window's first sample is summed. The bench drives long unbroken runs of valid samples, and also runs with random gaps, so that this overlap happens at every window boundary. A cycle-accurate bench model then judges it: a sample dropped or double-counted at the boundary shifts every later coefficient away from the modelled value.

// File: rtl/coef_adapter_pkg.sv
package coef_adapter_pkg;

  localparam int NUM_ORDERS = 3;

  // Control-to-datapath strobes for one clock cycle
  typedef struct packed {
    logic accumEn;   // sample accepted this cycle
    logic winClose;  // accepted sample is the last of its window
    logic applyUpd;  // write new coefficients at this edge
  } adaptStrobe_t;

endpackage

// File: rtl/coef_adapter_ctrl.sv
module coef_adapter_ctrl
  import coef_adapter_pkg::*;
#(
  parameter int WIN_LEN = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  output adaptStrobe_t strb,
  output logic         updStrobe
);

  localparam int CNT_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] sampleCnt;
  logic             applyQ;
  logic             closeNow;

  assign closeNow      = sampleValid && (sampleCnt == LAST_IDX);
  assign strb.accumEn  = sampleValid;
  assign strb.winClose = closeNow;
  assign strb.applyUpd = applyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      applyQ    <= 1'b0;
      updStrobe <= 1'b0;
    end else begin
      applyQ    <= closeNow;
      updStrobe <= applyQ;
      if (sampleValid) begin
        sampleCnt <= closeNow ? '0 : sampleCnt + 1'b1;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    sampleCnt <= LAST_IDX); // R3

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |=> !updStrobe); // R6

endmodule

// File: rtl/coef_lane.sv
module coef_lane
  import coef_adapter_pkg::*;
#(
  parameter int ACC_W     = 46,
  parameter int PROD_W    = 36,
  parameter int COEF_W    = 24,
  parameter int MUL_W     = 16,
  parameter int MU_MULT   = 27,
  parameter int MU_SHIFT  = 28,
  parameter int MOM_MULT  = 218,
  parameter int MOM_SHIFT = 8,
  parameter int INIT_VAL  = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  adaptStrobe_t             strb,
  input  logic signed [PROD_W-1:0] prodIn,
  output logic signed [COEF_W-1:0] coef
);

  localparam int BASE_W = (ACC_W > COEF_W) ? ACC_W : COEF_W;
  localparam int WIDE_W = BASE_W + MUL_W + 2;
  localparam int SUM_W  = COEF_W + 1;
  localparam logic signed [WIDE_W-1:0] MU_K  = WIDE_W'(MU_MULT);
  localparam logic signed [WIDE_W-1:0] MOM_K = WIDE_W'(MOM_MULT);
  localparam logic signed [COEF_W-1:0] C_MAX = {1'b0, {(COEF_W-1){1'b1}}};
  localparam logic signed [COEF_W-1:0] C_MIN = {1'b1, {(COEF_W-1){1'b0}}};
  localparam logic signed [COEF_W-1:0] C_INIT = COEF_W'(INIT_VAL);

  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  sumHold;
  logic signed [COEF_W-1:0] prevDelta;
  logic signed [WIDE_W-1:0] stepTerm;
  logic signed [WIDE_W-1:0] momTerm;
  logic signed [WIDE_W-1:0] deltaRaw;
  logic signed [COEF_W-1:0] delta;
  logic signed [SUM_W-1:0]  coefSum;
  logic signed [COEF_W-1:0] coefNext;

  always_comb begin
    stepTerm = (WIDE_W'(sumHold) * MU_K) >>> MU_SHIFT;
    momTerm  = (WIDE_W'(prevDelta) * MOM_K) >>> MOM_SHIFT;
    deltaRaw = stepTerm + momTerm;
    if (deltaRaw > WIDE_W'(C_MAX))      delta = C_MAX;
    else if (deltaRaw < WIDE_W'(C_MIN)) delta = C_MIN;
    else                                delta = deltaRaw[COEF_W-1:0];
    coefSum = SUM_W'(coef) + SUM_W'(delta);
    if (coefSum > SUM_W'(C_MAX))      coefNext = C_MAX;
    else if (coefSum < SUM_W'(C_MIN)) coefNext = C_MIN;
    else                              coefNext = coefSum[COEF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      sumHold   <= '0;
      prevDelta <= '0;
      coef      <= C_INIT;
    end else begin
      if (strb.winClose) begin
        sumHold <= acc + ACC_W'(prodIn);
        acc     <= '0;
      end else if (strb.accumEn) begin
        acc <= acc + ACC_W'(prodIn);
      end
      if (strb.applyUpd) begin
        coef      <= coefNext;
        prevDelta <= delta;
      end
    end
  end

  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accumEn |=> $stable(acc)); // R3

  AST_SUM_ONLY_ON_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.winClose |=> $stable(sumHold)); // R8

endmodule

// File: rtl/coef_adapter_dp.sv
module coef_adapter_dp
  import coef_adapter_pkg::*;
#(
  parameter int ERR_W     = 12,
  parameter int CODE_W    = 6,
  parameter int COEF_W    = 24,
  parameter int WIN_LEN   = 1000,
  parameter int MUL_W     = 16,
  parameter int MU_MULT   = 27,
  parameter int MU_SHIFT  = 28,
  parameter int MOM_MULT  = 218,
  parameter int MOM_SHIFT = 8,
  parameter int A1_INIT   = 262144,
  parameter int A3_INIT   = 0,
  parameter int A5_INIT   = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  adaptStrobe_t            strb,
  input  logic signed [ERR_W-1:0] errIn,
  input  logic signed [CODE_W-1:0] codeIn,
  input  logic                    ditherBit,
  output logic [NUM_ORDERS-1:0][COEF_W-1:0] coefBus
);

  localparam int P2_W   = 2 * CODE_W;
  localparam int P4_W   = 4 * CODE_W;
  localparam int PROD_W = ERR_W + P4_W;
  localparam int ACC_W  = PROD_W + $clog2(WIN_LEN + 1) + 1;

  logic signed [P2_W-1:0]   codeSq;
  logic signed [P4_W-1:0]   codeQuad;
  logic signed [PROD_W-1:0] powSel [NUM_ORDERS];

  // Code powers shared by all orders
  always_comb begin
    codeSq    = P2_W'(codeIn) * P2_W'(codeIn);
    codeQuad  = P4_W'(codeSq) * P4_W'(codeSq);
    powSel[0] = PROD_W'(1);
    powSel[1] = PROD_W'(codeSq);
    powSel[2] = PROD_W'(codeQuad);
  end

  for (genvar g = 0; g < NUM_ORDERS; g++) begin : g_order
    localparam int INIT_G = (g == 0) ? A1_INIT : ((g == 1) ? A3_INIT : A5_INIT);
    logic signed [PROD_W-1:0] magProd;
    logic signed [PROD_W-1:0] signedProd;
    logic signed [COEF_W-1:0] laneCoef;

    // The dither is +/-1, so it only selects a negation
    always_comb begin
      magProd    = PROD_W'(errIn) * powSel[g];
      signedProd = ditherBit ? magProd : -magProd;
    end

    coef_lane #(
      .ACC_W(ACC_W), .PROD_W(PROD_W), .COEF_W(COEF_W), .MUL_W(MUL_W),
      .MU_MULT(MU_MULT), .MU_SHIFT(MU_SHIFT),
      .MOM_MULT(MOM_MULT), .MOM_SHIFT(MOM_SHIFT), .INIT_VAL(INIT_G)
    ) lane_i (
      .clk(clk), .rstN(rstN), .strb(strb),
      .prodIn(signedProd), .coef(laneCoef)
    );

    assign coefBus[g] = laneCoef;
  end

endmodule

// File: rtl/coef_adapter.sv
module coef_adapter
  import coef_adapter_pkg::*;
#(
  parameter int ERR_W     = 12,
  parameter int CODE_W    = 6,
  parameter int COEF_W    = 24,
  parameter int WIN_LEN   = 1000,
  parameter int MUL_W     = 16,
  parameter int MU_MULT   = 27,
  parameter int MU_SHIFT  = 28,
  parameter int MOM_MULT  = 218,
  parameter int MOM_SHIFT = 8,
  parameter int A1_INIT   = 262144,
  parameter int A3_INIT   = 0,
  parameter int A5_INIT   = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [ERR_W-1:0]  errIn,
  input  logic signed [CODE_W-1:0] codeIn,
  input  logic                     ditherBit,
  output logic signed [COEF_W-1:0] coefA1,
  output logic signed [COEF_W-1:0] coefA3,
  output logic signed [COEF_W-1:0] coefA5,
  output logic                     coefUpdate
);

  adaptStrobe_t strb;
  logic [NUM_ORDERS-1:0][COEF_W-1:0] coefBus;

  coef_adapter_ctrl #(.WIN_LEN(WIN_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .strb(strb), .updStrobe(coefUpdate)
  );

  coef_adapter_dp #(
    .ERR_W(ERR_W), .CODE_W(CODE_W), .COEF_W(COEF_W), .WIN_LEN(WIN_LEN),
    .MUL_W(MUL_W), .MU_MULT(MU_MULT), .MU_SHIFT(MU_SHIFT),
    .MOM_MULT(MOM_MULT), .MOM_SHIFT(MOM_SHIFT),
    .A1_INIT(A1_INIT), .A3_INIT(A3_INIT), .A5_INIT(A5_INIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .errIn(errIn), .codeIn(codeIn), .ditherBit(ditherBit),
    .coefBus(coefBus)
  );

  assign coefA1 = $signed(coefBus[0]);
  assign coefA3 = $signed(coefBus[1]);
  assign coefA5 = $signed(coefBus[2]);

  AST_COEF_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !coefUpdate |-> ($stable(coefA1) && $stable(coefA3) && $stable(coefA5))); // R7

endmodule

// File: tb/coef_adapter_tb_top.sv
module coef_adapter_tb_top;

  localparam int ERR_W     = 12;
  localparam int CODE_W    = 6;
  localparam int COEF_W    = 24;
  localparam int WIN_LEN   = 8;
  localparam int MU_MULT   = 27;
  localparam int MU_SHIFT  = 14;
  localparam int MOM_MULT  = 218;
  localparam int MOM_SHIFT = 8;
  localparam int A1_INIT   = 262144;
  localparam longint C_MAX = (64'sd1 <<< (COEF_W - 1)) - 1;
  localparam longint C_MIN = -(64'sd1 <<< (COEF_W - 1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [ERR_W-1:0]  errIn = '0;
  logic signed [CODE_W-1:0] codeIn = '0;
  logic ditherBit = 1'b0;
  logic signed [COEF_W-1:0] coefA1, coefA3, coefA5;
  logic coefUpdate;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Reference state
  longint mAcc [3];
  longint mSum [3];
  longint mCoef [3];
  longint mPrev [3];
  int     mCnt;
  bit     mPend;
  bit     mStrobe;

  always #2 clk = ~clk;  // 250 MHz

  coef_adapter #(
    .ERR_W(ERR_W), .CODE_W(CODE_W), .COEF_W(COEF_W), .WIN_LEN(WIN_LEN),
    .MU_MULT(MU_MULT), .MU_SHIFT(MU_SHIFT),
    .MOM_MULT(MOM_MULT), .MOM_SHIFT(MOM_SHIFT), .A1_INIT(A1_INIT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .errIn(errIn), .codeIn(codeIn), .ditherBit(ditherBit),
    .coefA1(coefA1), .coefA3(coefA3), .coefA5(coefA5),
    .coefUpdate(coefUpdate)
  );

  function automatic longint clampC(longint x);
    if (x > C_MAX) return C_MAX;
    if (x < C_MIN) return C_MIN;
    return x;
  endfunction

  function automatic longint orderProd(int ord, longint e, longint c, bit d);
    longint p;
    p = (ord == 0) ? e : ((ord == 1) ? e * c * c : e * c * c * c * c);
    return d ? p : -p;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 3; i++) begin
      mAcc[i] = 0; mSum[i] = 0; mPrev[i] = 0;
      mCoef[i] = (i == 0) ? longint'(A1_INIT) : 0;
    end
    mCnt = 0; mPend = 1'b0; mStrobe = 1'b0;
  endtask

  // One clock edge of the reference, following R2..R9
  task automatic modelEdge(bit v, longint e, longint c, bit d);
    bit doApply;
    doApply = mPend;
    mStrobe = doApply;
    if (doApply) begin
      for (int i = 0; i < 3; i++) begin
        longint dl;
        dl = ((mSum[i] * MU_MULT) >>> MU_SHIFT) + ((mPrev[i] * MOM_MULT) >>> MOM_SHIFT);
        dl = clampC(dl);
        mPrev[i] = dl;
        mCoef[i] = clampC(mCoef[i] + dl);
      end
    end
    mPend = 1'b0;
    if (v) begin
      for (int i = 0; i < 3; i++) mAcc[i] += orderProd(i, e, c, d);
      if (mCnt == WIN_LEN - 1) begin
        for (int i = 0; i < 3; i++) begin
          mSum[i] = mAcc[i];
          mAcc[i] = 0;
        end
        mCnt = 0;
        mPend = 1'b1;
      end else begin
        mCnt++;
      end
    end
  endtask

  task automatic compareOut(string tag);
    bit bad;
    checks++;
    bad = (longint'(coefA1) != mCoef[0]) || (longint'(coefA3) != mCoef[1]) ||
          (longint'(coefA5) != mCoef[2]) || (coefUpdate != mStrobe);
    if (bad) begin
      errors++;
      $display("FAIL %s: got a1=%0d a3=%0d a5=%0d upd=%0b expected a1=%0d a3=%0d a5=%0d upd=%0b",
               tag, coefA1, coefA3, coefA5, coefUpdate, mCoef[0], mCoef[1], mCoef[2], mStrobe);
    end
  endtask

  // Drive at negedge, advance model, check at next negedge
  task automatic stepCycle(bit v, int e, int c, bit d, string tag);
    sampleValid = v;
    errIn       = ERR_W'(e);
    codeIn      = CODE_W'(c);
    ditherBit   = d;
    modelEdge(v, longint'(e), longint'(c), d);
    @(posedge clk);
    @(negedge clk);
    compareOut(tag);
  endtask

  task automatic randCycle(int validPct, int eSpan, string tag);
    bit v;
    int e, c;
    v = ($urandom_range(99) < validPct);
    e = int'($urandom_range(2 * eSpan)) - eSpan;
    c = int'($urandom_range(63)) - 32;
    stepCycle(v, e, c, $urandom_range(1), tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    checks++;
    if (coefA1 !== 24'sd262144 || coefA3 !== '0 || coefA5 !== '0 || coefUpdate !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: got a1=%0d a3=%0d a5=%0d upd=%0b expected a1=262144 a3=0 a5=0 upd=0",
               coefA1, coefA3, coefA5, coefUpdate);
    end
    rstN = 1'b1;
    @(negedge clk);
    compareOut("R1 after reset");

    // R1: all-zero error window leaves coefficients at their reset values
    for (int i = 0; i < WIN_LEN + 2; i++) stepCycle(1'b1, 0, 17, i[0], "R1 zero window");

    // R2: fixed error and code, dither +1 then -1
    for (int i = 0; i < WIN_LEN + 2; i++) stepCycle(1'b1, 37, 5, 1'b1, "R2 dither plus");
    for (int i = 0; i < WIN_LEN + 2; i++) stepCycle(1'b1, 37, -3, 1'b0, "R2 dither minus");

    // R3: sparse valid, invalid cycles carry large values that must be ignored
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 0) stepCycle(1'b1, 21, 4, 1'b1, "R3 gated window");
      else            stepCycle(1'b0, 2047, -32, 1'b1, "R3 ignored sample");
    end

    // R5: zero error after nonzero windows: momentum alone moves coefficients
    for (int i = 0; i < 4 * WIN_LEN; i++) stepCycle(1'b1, 0, 9, 1'b1, "R5 momentum decay");

    // R8: unbroken valid stream across many boundaries
    for (int i = 0; i < 30 * WIN_LEN; i++) randCycle(100, 200, "R8 back-to-back");

    // R4, R6, R7: random gaps and values
    for (int i = 0; i < 600; i++) randCycle(70, 300, "R4 R6 R7 random");

    // R9: extreme products drive both delta and coefficients into clamps
    for (int i = 0; i < 3 * WIN_LEN; i++) stepCycle(1'b1, 2047, -32, 1'b1, "R9 saturate high");
    for (int i = 0; i < 6 * WIN_LEN; i++) stepCycle(1'b1, -2048, -32, 1'b1, "R9 saturate low");
    for (int i = 0; i < 4 * WIN_LEN; i++) stepCycle(1'b1, 0, 0, 1'b0, "R9 after clamp");

    // R7: long idle, nothing may change
    for (int i = 0; i < 20; i++) stepCycle(1'b0, 5, 5, 1'b1, "R7 idle hold");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule